// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block keeps the control state for a bank of DMA channels and decides, one burst at a time, whether a device-side transfer may proceed and how large it is. Each channel owns a mode/status word, a remaining byte count, a start address and one spare word. Software programs and inspects them through a 32-bit register port with a combinational read path and single-cycle writes.

A device raises a request that names a channel, the direction it wants (memory to device, or device to memory) and the number of bytes it would like to move. In the same cycle the block answers with a go/no-go decision, the address to use and the clamped length. At the next clock edge the channel's status flags and count are updated. A request on a disabled channel, or one whose direction disagrees with the channel's programmed direction, is refused. The refusal is recorded in the channel's mode word and in a shared error-source vector that drives a non-maskable interrupt line. Data movement and address translation happen elsewhere.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every channel register, the error-source vector and `err_src` read as zero, and `xfer_go`, `xfer_len` and `xfer_addr` are zero while no request is present.
- R2: Channel n occupies byte offsets 0x100 + 0x20*n. Inside it, bits [4:3] of the offset select mode (0), count (1), address (2) or spare (3), and bits [2:0] are ignored. All 32 bits of each register read back as written. The error-source vector reads at offset 0x200 (bits [2:0] ignored). Any other offset reads zero and ignores writes.
- R3: Every request, accepted or refused, clears mode bits 8 (terminal count), 9 (memory error) and 10 (address error) of its channel before any new flag is set, and leaves the other mode bits unchanged.
- R4: A request is refused when mode bit 0 (enable) is clear or when `req_to_dev` differs from mode bit 1 (1 = memory to device). A refusal keeps `xfer_go` low, sets mode bit 9, sets bit n of the error-source vector, and leaves the count unchanged.
- R5: An accepted request raises `xfer_go` combinationally in the same cycle, with `xfer_len` = min(`req_len`, count) and `xfer_addr` = the channel's address register.
- R6: After an accepted request, mode bit 8 is set and the count is reduced by `xfer_len`. The address register is not advanced.
- R7: A CPU write to a channel register in the same cycle as a request on that channel sets that register to the written value. The hardware update of the channel's other registers still takes place.
- R8: Writing to offset 0x200 clears each error-source bit whose data bit is 1. A refusal in the same cycle still sets its bit.
- R9: A request changes only the registers of the channel it names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| req_valid | input | 1 | Burst request present |
| req_ch | input | log2(NUM_CH) | Requested channel |
| req_to_dev | input | 1 | Requested direction, 1 = memory to device |
| req_len | input | 32 | Requested byte length |
| xfer_go | output | 1 | Request accepted |
| xfer_addr | output | 32 | Transfer start address (zero when not accepted) |
| xfer_len | output | 32 | Clamped transfer length (zero when not accepted) |
| err_src | output | NUM_CH | Per-channel error source, non-maskable interrupt request |

## Verification
On every cycle, the assertions check the state after each edge. An accepted burst leaves terminal count set and memory error clear. A refusal sets both the channel's memory-error bit and its error-source bit. No count grows, no address changes, and no mode word moves unless a request or a write names its channel. The clamped length is also checked against the request and the count whenever a burst is accepted. Only the bench's scenarios can show the rest: the register map decode, the exact count arithmetic across chained bursts down to zero, write priority on a collision, and the clear-versus-set order in the error-source vector. It exercises these against a reference model, mixing random traffic with directed collisions.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 10,
  parameter int DW     = 32,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              req_valid,
  input  logic [CHW-1:0]    req_ch,
  input  logic              req_to_dev,
  input  logic [DW-1:0]     req_len,
  output logic              xfer_go,
  output logic [DW-1:0]     xfer_addr,
  output logic [DW-1:0]     xfer_len,
  output logic [NUM_CH-1:0] err_src
);

  localparam int EN_BIT   = 0;
  localparam int DIR_BIT  = 1;
  localparam int TC_BIT   = 8;
  localparam int MERR_BIT = 9;
  localparam int AERR_BIT = 10;
  localparam logic [DW-1:0] FLAG_MASK =
    (DW'(1) << TC_BIT) | (DW'(1) << MERR_BIT) | (DW'(1) << AERR_BIT);
  localparam int SRC_OFF = 'h200;

  logic [DW-1:0] mode_q  [NUM_CH];
  logic [DW-1:0] cnt_q   [NUM_CH];
  logic [DW-1:0] addr_q  [NUM_CH];
  logic [DW-1:0] spare_q [NUM_CH];
  logic [NUM_CH-1:0] err_q;

  logic [2:0]     ch_field;
  logic           ch_hit, src_hit, ch_wr, src_wr;
  logic [CHW-1:0] wr_ch;
  logic [1:0]     wr_idx;
  logic [DW-1:0]  cur_mode, cur_cnt;
  logic           chan_ok, reject;
  logic [NUM_CH-1:0] err_set;

  assign ch_field = reg_addr[7:5];
  assign ch_hit   = (reg_addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) &&
                    ({1'b0, ch_field} < 4'(NUM_CH));
  assign src_hit  = (reg_addr[ADDR_W-1:3] == (ADDR_W-3)'(SRC_OFF >> 3));
  assign ch_wr    = reg_wen && ch_hit;
  assign src_wr   = reg_wen && src_hit;
  assign wr_ch    = reg_addr[CHW+4:5];
  assign wr_idx   = reg_addr[4:3];

  assign cur_mode = mode_q[req_ch];
  assign cur_cnt  = cnt_q[req_ch];
  assign chan_ok  = req_valid && cur_mode[EN_BIT] && (req_to_dev == cur_mode[DIR_BIT]);
  assign reject   = req_valid && !chan_ok;

  assign xfer_go   = chan_ok;
  assign xfer_len  = !chan_ok ? '0 : ((req_len < cur_cnt) ? req_len : cur_cnt);
  assign xfer_addr = chan_ok ? addr_q[req_ch] : '0;

  assign err_set = reject ? (NUM_CH'(1) << req_ch) : '0;
  assign err_src = err_q;

  always_comb begin
    reg_rdata = '0;
    if (ch_hit) begin
      case (wr_idx)
        2'd0: reg_rdata = mode_q[wr_ch];
        2'd1: reg_rdata = cnt_q[wr_ch];
        2'd2: reg_rdata = addr_q[wr_ch];
        default: reg_rdata = spare_q[wr_ch];
      endcase
    end else if (src_hit) begin
      reg_rdata = DW'(err_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        mode_q[i]  <= '0;
        cnt_q[i]   <= '0;
        addr_q[i]  <= '0;
        spare_q[i] <= '0;
      end
      err_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (req_valid && req_ch == CHW'(i)) begin
          mode_q[i] <= (mode_q[i] & ~FLAG_MASK) |
                       (chan_ok ? (DW'(1) << TC_BIT) : (DW'(1) << MERR_BIT));
          if (chan_ok) cnt_q[i] <= cnt_q[i] - xfer_len;
        end
        if (ch_wr && wr_ch == CHW'(i)) begin
          case (wr_idx)
            2'd0: mode_q[i]  <= reg_wdata;
            2'd1: cnt_q[i]   <= reg_wdata;
            2'd2: addr_q[i]  <= reg_wdata;
            default: spare_q[i] <= reg_wdata;
          endcase
        end
      end
      err_q <= (err_q & ~(src_wr ? reg_wdata[NUM_CH-1:0] : '0)) | err_set;
    end
  end

  // R5
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (xfer_len <= req_len) && (xfer_len <= cnt_q[req_ch]));

  // R6
  good_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !(ch_wr && wr_ch == req_ch && wr_idx == 2'd0))
    |=> mode_q[$past(req_ch)][TC_BIT] && !mode_q[$past(req_ch)][MERR_BIT]);

  // R4
  bad_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !(ch_wr && wr_ch == req_ch && wr_idx == 2'd0))
    |=> mode_q[$past(req_ch)][MERR_BIT] && !mode_q[$past(req_ch)][TC_BIT]
        && !mode_q[$past(req_ch)][AERR_BIT]);

  // R4
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_src[$past(req_ch)]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R6
    cnt_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_wr && wr_ch == CHW'(g) && wr_idx == 2'd1) |=> cnt_q[g] <= $past(cnt_q[g]));
    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_wr && wr_ch == CHW'(g) && wr_idx == 2'd2) |=> $stable(addr_q[g]));
    // R9
    mode_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_wr && wr_ch == CHW'(g) && wr_idx == 2'd0) && !(req_valid && req_ch == CHW'(g))
      |=> $stable(mode_q[g]));
  end

endmodule

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  reg_addr;
  logic        reg_wen;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_valid, req_to_dev;
  logic [2:0]  req_ch;
  logic [31:0] req_len, xfer_addr, xfer_len;
  logic        xfer_go;
  logic [NCH-1:0] err_src;

  always #4 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ch(req_ch), .req_to_dev(req_to_dev), .req_len(req_len),
    .xfer_go(xfer_go), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .err_src(err_src)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_mode[NCH], m_cnt[NCH], m_addr[NCH], m_spare[NCH];
  logic [NCH-1:0] m_err;

  function automatic logic [31:0] min_len(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [9:0] reg_off(input int ch, input int idx);
    return 10'(32'h100 + ch * 32 + idx * 8);
  endfunction

  function automatic logic [31:0] model_read(input logic [9:0] a);
    if (a[9:8] == 2'b01) begin
      case (a[4:3])
        2'd0: return m_mode[a[7:5]];
        2'd1: return m_cnt[a[7:5]];
        2'd2: return m_addr[a[7:5]];
        default: return m_spare[a[7:5]];
      endcase
    end
    if (a[9:3] == 7'h40) return 32'(m_err);
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rv, input int ch, input bit todev, input logic [31:0] len,
                      input bit wv, input logic [9:0] wa, input logic [31:0] wd);
    bit ok;
    logic [31:0] elen;
    logic [NCH-1:0] set;
    @(negedge clk);
    req_valid = rv; req_ch = 3'(ch); req_to_dev = todev; req_len = len;
    reg_wen = wv; reg_addr = wa; reg_wdata = wd;
    #1;
    ok   = rv && m_mode[ch][0] && (todev == m_mode[ch][1]);
    elen = ok ? min_len(len, m_cnt[ch]) : 32'h0;
    check(ok ? "R5 go" : "R4 go", 32'(xfer_go), 32'(ok));
    check("R5 len", xfer_len, elen);
    check("R5 addr", xfer_addr, ok ? m_addr[ch] : 32'h0);
    check("R8 err_src", 32'(err_src), 32'(m_err));
    @(posedge clk);
    set = '0;
    if (rv) begin
      m_mode[ch] = m_mode[ch] & ~32'h700;
      if (ok) begin
        m_mode[ch] = m_mode[ch] | 32'h100;
        m_cnt[ch]  = m_cnt[ch] - elen;
      end else begin
        m_mode[ch] = m_mode[ch] | 32'h200;
        set = NCH'(1) << ch;
      end
    end
    if (wv) begin
      if (wa[9:8] == 2'b01) begin
        case (wa[4:3])
          2'd0: m_mode[wa[7:5]]  = wd;
          2'd1: m_cnt[wa[7:5]]   = wd;
          2'd2: m_addr[wa[7:5]]  = wd;
          default: m_spare[wa[7:5]] = wd;
        endcase
      end else if (wa[9:3] == 7'h40) begin
        m_err = m_err & ~wd[NCH-1:0];
      end
    end
    m_err = m_err | set;
    #1;
    req_valid = 1'b0; reg_wen = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    step(0, 0, 0, 0, 1, a, d);
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    @(negedge clk);
    reg_addr = a; reg_wen = 1'b0; req_valid = 1'b0;
    #1;
    check(tag, reg_rdata, model_read(a));
  endtask

  task automatic rd_chan(input int ch, input string tag);
    for (int i = 0; i < 4; i++) rd(reg_off(ch, i), tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NCH; i++) begin
      m_mode[i] = 0; m_cnt[i] = 0; m_addr[i] = 0; m_spare[i] = 0;
    end
    m_err = '0;
    rst_n = 1'b0; reg_wen = 0; reg_addr = 0; reg_wdata = 0;
    req_valid = 0; req_ch = 0; req_to_dev = 0; req_len = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < NCH; c++) rd_chan(c, "R1 reset reg");
    rd(10'h200, "R1 reset src");
    check("R1 go idle", 32'(xfer_go), 32'h0);
    check("R1 err_src", 32'(err_src), 32'h0);

    // R2 map and readback, including ignored low bits and unmapped offsets
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 4; i++) wr(reg_off(c, i), $urandom);
    for (int c = 0; c < NCH; c++) rd_chan(c, "R2 readback");
    wr(reg_off(6, 3) | 10'h5, 32'hCAFE_0001);
    rd(reg_off(6, 3), "R2 low bits ignored");
    wr(10'h300, 32'hFFFF_FFFF);
    rd(10'h300, "R2 unmapped reads zero");
    for (int c = 0; c < NCH; c++) rd_chan(c, "R2 unmapped write ignored");

    // R5 R6 directed chain on channel 2, device to memory
    wr(reg_off(2, 0), 32'h0000_0701);
    wr(reg_off(2, 1), 32'd100);
    wr(reg_off(2, 2), 32'h0000_1234);
    step(1, 2, 0, 32'd40, 0, 0, 0);
    rd_chan(2, "R6 after first burst");
    step(1, 2, 0, 32'd200, 0, 0, 0);
    check("R6 count zero", m_cnt[2], 32'd0);
    rd_chan(2, "R6 clamp to zero");
    step(1, 2, 0, 32'd5, 0, 0, 0);
    rd_chan(2, "R6 empty burst");

    // R4 direction mismatch and disabled channel
    step(1, 2, 1, 32'd8, 0, 0, 0);
    rd_chan(2, "R4 mismatch");
    wr(reg_off(5, 0), 32'h0000_0402);
    step(1, 5, 1, 32'd8, 0, 0, 0);
    rd_chan(5, "R3 R4 disabled");
    rd(10'h200, "R4 src bits");

    // R8 clear, and clear colliding with a set
    wr(10'h200, 32'h0000_0004);
    rd(10'h200, "R8 w1c");
    wr(reg_off(3, 0), 32'h0);
    step(1, 3, 0, 32'd1, 1, 10'h200, 32'h0000_0008);
    rd(10'h200, "R8 set beats clear");

    // R7 collisions
    wr(reg_off(1, 0), 32'h0000_0003);
    wr(reg_off(1, 1), 32'd50);
    step(1, 1, 1, 32'd10, 1, reg_off(1, 1), 32'd999);
    rd_chan(1, "R7 count write wins");
    step(1, 1, 1, 32'd10, 1, reg_off(1, 0), 32'h0000_0402);
    rd_chan(1, "R7 mode write wins");

    // random traffic
    for (int k = 0; k < 800; k++) begin
      int op  = $urandom_range(0, 9);
      int c   = $urandom_range(0, NCH - 1);
      int idx = $urandom_range(0, 3);
      logic [31:0] v;
      v = (idx == 0) ? (($urandom & 32'h702) | 32'($urandom_range(0, 3) != 0)) :
          (idx == 1) ? 32'($urandom_range(0, 500)) : $urandom;
      if (op < 4)       step(1, c, 1'($urandom_range(0, 1)), 32'($urandom_range(0, 300)), 0, 0, 0);
      else if (op < 7)  wr(reg_off(c, idx), v);
      else if (op == 7) step(1, c, 1'($urandom_range(0, 1)), 32'($urandom_range(0, 300)),
                             1, reg_off(c, idx), v);
      else if (op == 8) wr(10'h200, $urandom);
      else              rd_chan(c, "R9 random readback");
    end
    for (int c = 0; c < NCH; c++) rd_chan(c, "R9 final");
    rd(10'h200, "R8 final src");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule